// File: doc/BRIEF.md
# PHY Management Register Bank

This block is a memory-mapped model of the management register file of a 10/100 Ethernet PHY. It holds 32 sixteen-bit PHY registers and fills them with fixed values at reset. Host software reaches them through four 32-bit host registers: a command word, an address word, a write-data word and a read-status word. Software first sets the PHY address and the register address in the address word. A write to the write-data word stores that value in the selected PHY register. A command write with its read bit set copies the selected PHY register into the read-status word.

Only one PHY address answers; the default is 1. The model completes soft-reset and auto-negotiation requests at once. An external link input drives the link bit and the negotiation-complete bit of the basic status register. The block is used where firmware expects a PHY management unit and no serial pin-level interface is needed.

Top module: `phy_mgmt_bank`

## Requirements
- R1: After reset the PHY registers hold: index 0 (control) 0x1140, index 1 (status) 0x7968 with bits 2 and 5 both equal to the link input, index 2 0x0022, index 3 0x1550, index 4 0x01E1, index 5 0xCDE1. Every other index holds 0. After reset the host read data is 0.
- R2: The host word offsets are: command 0, address 1, write-data 2, read-status 3. A read returns data on the clock after the read strobe. The address word keeps bits [4:0] (register index) and bits [12:8] (PHY address). The write-data word keeps bits [15:0]. The command word reads as 0. All other bits read as 0.
- R3: A host write to the write-data word, while the address word selects the responding PHY, stores the low 16 bits in the selected PHY register.
- R4: A command write with bit 0 set loads the selected PHY register into the read-status word.
- R5: When the selected PHY address is not the responding one, a read command loads 0xFFFF and a write-data write leaves every PHY register unchanged.
- R6: A write to control (index 0) with bit 15 set first restores every R1 value. It then stores the written value with bit 15 cleared.
- R7: A write to control with bit 12 set stores that bit as 0 and sets bit 5 of status (index 1) in the same clock.
- R8: After a change on the link input, status bits 2 and 5 both equal the new link value on the next clock edge.
- R9: If a host write to status coincides with a link change, bits 2 and 5 take the link value and every other bit takes the written data.
- R10: A command write with bit 0 clear leaves the read-status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busAddr | input | HOST_AW | Host word offset |
| busWrData | input | BUS_W | Host write data |
| busRdData | output | BUS_W | Host read data, valid one clock after busRdEn |
| linkUp | input | 1 | External link state, 1 = link up |

## Verification
PHY writes go to register indices 4 and 31, and each is read back. This shows whether the register index is decoded fully or only in part. Reads aimed at PHY address 2 and at 0x11 must return 0xFFFF. The 0x11 case shares its low bits with the responding address, so a compare that drops bit 12 of the address word is caught. Foreign writes must leave a known value in place. The link input is lowered and raised around an auto-negotiation request. This separates the fixed reset pattern, the effect of the request and the link override. A status write that lands in the same clock as a link drop shows which source wins for bits 2 and 5.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int PHY_DW  = 16;
  localparam int PHY_RAW = 5;
  localparam int PHY_NREG = 2 ** PHY_RAW;
  localparam int PHY_PAW = 5;

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;

  localparam int CTRL_SOFTRST = 15;
  localparam int CTRL_ANEG    = 12;
  localparam int STAT_LINK    = 2;
  localparam int STAT_ANDONE  = 5;

  localparam int HOST_CMD  = 0;
  localparam int HOST_ADDR = 1;
  localparam int HOST_WDAT = 2;
  localparam int HOST_STS  = 3;

  typedef struct packed {
    logic               phyWr;
    logic [PHY_RAW-1:0] regIdx;
    logic [PHY_DW-1:0]  wrData;
  } phyStrobe_t;

  function automatic logic [PHY_DW-1:0] phyResetWord(input int idx, input logic link);
    logic [PHY_DW-1:0] v;
    case (idx)
      0: v = 16'h1140;
      1: v = 16'h7968;
      2: v = 16'h0022;
      3: v = 16'h1550;
      4: v = 16'h01E1;
      5: v = 16'hCDE1;
      default: v = '0;
    endcase
    if (idx == IDX_STAT) begin
      v[STAT_LINK]   = link;
      v[STAT_ANDONE] = link;
    end
    return v;
  endfunction
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int HOST_AW  = 2,
  parameter int BUS_W    = 32,
  parameter int PHY_ADDR = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [HOST_AW-1:0] busAddr,
  input  logic [BUS_W-1:0]   busWrData,
  output logic [BUS_W-1:0]   busRdData,
  input  logic [PHY_DW-1:0]  phyRdData,
  output logic [PHY_RAW-1:0] phyRdIdx,
  output phyStrobe_t         strb
);
  localparam int PA_LO = 8;
  localparam int PA_HI = PA_LO + PHY_PAW - 1;

  logic [PHY_PAW-1:0] phySel;
  logic [PHY_RAW-1:0] regSel;
  logic [PHY_DW-1:0]  wdatReg;
  logic [PHY_DW-1:0]  stsReg;
  logic               phyMatch;
  logic               cmdRead;
  logic [BUS_W-1:0]   rdMux;
  logic               unusedHi;

  assign phyMatch = (phySel == PHY_PAW'(PHY_ADDR));
  assign cmdRead  = busWrEn && (busAddr == HOST_AW'(HOST_CMD)) && busWrData[0];
  assign phyRdIdx = regSel;
  assign unusedHi = ^busWrData[BUS_W-1:PHY_DW];

  always_comb begin
    strb.phyWr  = busWrEn && (busAddr == HOST_AW'(HOST_WDAT)) && phyMatch;
    strb.regIdx = regSel;
    strb.wrData = busWrData[PHY_DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phySel  <= '0;
      regSel  <= '0;
      wdatReg <= '0;
      stsReg  <= '0;
    end else if (busWrEn) begin
      if (busAddr == HOST_AW'(HOST_ADDR)) begin
        phySel <= busWrData[PA_HI:PA_LO];
        regSel <= busWrData[PHY_RAW-1:0];
      end
      if (busAddr == HOST_AW'(HOST_WDAT)) wdatReg <= busWrData[PHY_DW-1:0];
      if (cmdRead) stsReg <= phyMatch ? phyRdData : '1;
    end
  end

  always_comb begin
    rdMux = '0;
    case (busAddr)
      HOST_AW'(HOST_ADDR): begin
        rdMux[PA_HI:PA_LO]   = phySel;
        rdMux[PHY_RAW-1:0]   = regSel;
      end
      HOST_AW'(HOST_WDAT): rdMux[PHY_DW-1:0] = wdatReg;
      HOST_AW'(HOST_STS):  rdMux[PHY_DW-1:0] = stsReg;
      default:             rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busRdData <= '0;
    else if (busRdEn) busRdData <= rdMux;
  end

  // R5
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdRead && !phyMatch) |=> (stsReg == '1));

  // R4
  local_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdRead && phyMatch) |=> (stsReg == $past(phyRdData)));

  // R10
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdRead |=> $stable(stsReg));
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               linkUp,
  input  phyStrobe_t         strb,
  input  logic [PHY_RAW-1:0] rdIdx,
  output logic [PHY_DW-1:0]  rdData
);
  logic [PHY_NREG-1:0][PHY_DW-1:0] regs;
  logic [PHY_NREG-1:0][PHY_DW-1:0] regsNxt;
  logic linkPrev;
  logic linkChg;
  logic [PHY_DW-1:0] wv;

  assign linkChg = (linkUp != linkPrev);
  assign rdData  = regs[rdIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) linkPrev <= linkUp;
    else        linkPrev <= linkUp;
  end

  always_comb begin
    regsNxt = regs;
    wv      = strb.wrData;
    if (strb.phyWr) begin
      if (strb.regIdx == PHY_RAW'(IDX_CTRL)) begin
        if (wv[CTRL_SOFTRST]) begin
          for (int i = 0; i < PHY_NREG; i++) regsNxt[i] = phyResetWord(i, linkUp);
          wv[CTRL_SOFTRST] = 1'b0;
        end
        if (wv[CTRL_ANEG]) begin
          wv[CTRL_ANEG] = 1'b0;
          regsNxt[IDX_STAT][STAT_ANDONE] = 1'b1;
        end
      end
      regsNxt[strb.regIdx] = wv;
    end
    if (linkChg) begin
      regsNxt[IDX_STAT][STAT_LINK]   = linkUp;
      regsNxt[IDX_STAT][STAT_ANDONE] = linkUp;
    end
  end

  for (genvar g = 0; g < PHY_NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= phyResetWord(g, linkUp);
      else        regs[g] <= regsNxt[g];
    end
  end

  // R8
  link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkChg |=> (regs[IDX_STAT][STAT_LINK] == $past(linkUp)) &&
                (regs[IDX_STAT][STAT_ANDONE] == $past(linkUp)));

  // R7
  aneg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.phyWr && strb.regIdx == PHY_RAW'(IDX_CTRL) && strb.wrData[CTRL_ANEG] && !linkChg)
      |=> (regs[IDX_STAT][STAT_ANDONE] && !regs[IDX_CTRL][CTRL_ANEG]));

  // R6
  softrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.phyWr && strb.regIdx == PHY_RAW'(IDX_CTRL)) |=> !regs[IDX_CTRL][CTRL_SOFTRST]);

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.phyWr && !linkChg) |=> $stable(regs));
endmodule

// File: rtl/phy_mgmt_bank.sv
module phy_mgmt_bank
  import phy_mgmt_pkg::*;
#(
  parameter int HOST_AW  = 2,
  parameter int BUS_W    = 32,
  parameter int PHY_ADDR = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [HOST_AW-1:0] busAddr,
  input  logic [BUS_W-1:0]   busWrData,
  output logic [BUS_W-1:0]   busRdData,
  input  logic               linkUp
);
  phyStrobe_t         strb;
  logic [PHY_DW-1:0]  phyRdData;
  logic [PHY_RAW-1:0] phyRdIdx;

  phy_mgmt_ctrl #(.HOST_AW(HOST_AW), .BUS_W(BUS_W), .PHY_ADDR(PHY_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .phyRdData(phyRdData), .phyRdIdx(phyRdIdx), .strb(strb)
  );

  phy_mgmt_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .linkUp(linkUp), .strb(strb),
    .rdIdx(phyRdIdx), .rdData(phyRdData)
  );
endmodule

// File: tb/phy_mgmt_bank_tb.sv
module phy_mgmt_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        busWrEn = 0;
  logic        busRdEn = 0;
  logic [1:0]  busAddr = 0;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;
  logic        linkUp = 1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_bank u_dut (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .linkUp(linkUp)
  );

  function automatic logic [15:0] expReset(input int i, input logic lk);
    logic [15:0] v;
    case (i)
      0: v = 16'h1140; 1: v = 16'h7968; 2: v = 16'h0022;
      3: v = 16'h1550; 4: v = 16'h01E1; 5: v = 16'hCDE1;
      default: v = 16'h0;
    endcase
    if (i == 1) begin v[2] = lk; v[5] = lk; end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busRdEn = 0;
    d = busRdData;
  endtask

  task automatic phyWrite(input int phy, input int idx, input logic [15:0] d);
    busWrite(2'd1, (32'(phy) << 8) | 32'(idx));
    busWrite(2'd2, {16'hDEAD, d});
  endtask

  task automatic phyRead(input int phy, input int idx, output logic [15:0] d);
    logic [31:0] r;
    busWrite(2'd1, (32'(phy) << 8) | 32'(idx));
    busWrite(2'd0, 32'h1);
    busRead(2'd3, r);
    d = r[15:0];
  endtask

  task automatic testResetValues();
    logic [15:0] v;
    check("R1 rdData after reset", busRdData, 32'h0);
    for (int i = 0; i < 32; i++) begin
      phyRead(1, i, v);
      check($sformatf("R1 reset idx %0d", i), {16'h0, v}, {16'h0, expReset(i, 1'b1)});
    end
  endtask

  task automatic testHostMap();
    logic [31:0] r;
    busWrite(2'd1, 32'hFFFF_FFFF);
    busRead(2'd1, r);
    check("R2 address word fields", r, 32'h0000_1F1F);
    busWrite(2'd2, 32'hABCD_1234);
    busRead(2'd2, r);
    check("R2 write-data word width", r, 32'h0000_1234);
    busRead(2'd0, r);
    check("R2 command reads zero", r, 32'h0);
  endtask

  task automatic testWriteRead();
    logic [15:0] v;
    phyWrite(1, 4, 16'h5A5A);
    phyRead(1, 4, v);
    check("R3 R4 write/read idx 4", {16'h0, v}, 32'h5A5A);
    phyWrite(1, 31, 16'hBEEF);
    phyRead(1, 31, v);
    check("R3 R4 write/read idx 31", {16'h0, v}, 32'hBEEF);
  endtask

  task automatic testForeign();
    logic [15:0] v;
    logic [31:0] r;
    phyRead(2, 4, v);
    check("R5 read phy 2", {16'h0, v}, 32'hFFFF);
    phyRead(17, 4, v);
    check("R5 read phy 0x11", {16'h0, v}, 32'hFFFF);
    phyWrite(2, 4, 16'h1111);
    phyWrite(17, 4, 16'h2222);
    phyRead(1, 4, v);
    check("R5 foreign write ignored", {16'h0, v}, 32'h5A5A);
    busWrite(2'd0, 32'h0);
    busRead(2'd3, r);
    check("R10 command without read bit", r, 32'h5A5A);
  endtask

  task automatic testLinkAneg();
    logic [15:0] v;
    @(negedge clk); linkUp = 0;
    @(posedge clk);
    phyRead(1, 1, v);
    check("R8 link down status", {16'h0, v}, 32'h7948);
    phyWrite(1, 0, 16'h1000);
    phyRead(1, 0, v);
    check("R7 aneg bit cleared in control", {16'h0, v}, 32'h0000);
    phyRead(1, 1, v);
    check("R7 aneg done set", {16'h0, v}, 32'h7968);
    @(negedge clk); linkUp = 1;
    @(posedge clk);
    phyRead(1, 1, v);
    check("R8 link up status", {16'h0, v}, 32'h796C);
  endtask

  task automatic testSoftReset();
    logic [15:0] v;
    phyWrite(1, 4, 16'h7777);
    phyWrite(1, 0, 16'h8100);
    phyRead(1, 0, v);
    check("R6 control after soft reset", {16'h0, v}, 32'h0100);
    phyRead(1, 4, v);
    check("R6 idx 4 restored", {16'h0, v}, 32'h01E1);
    phyRead(1, 31, v);
    check("R6 idx 31 cleared", {16'h0, v}, 32'h0);
    phyRead(1, 1, v);
    check("R6 status restored", {16'h0, v}, 32'h796C);
  endtask

  task automatic testCollision();
    logic [15:0] v;
    busWrite(2'd1, 32'h0000_0101);
    @(negedge clk);
    linkUp = 0; busWrEn = 1; busAddr = 2'd2; busWrData = 32'h0000_00FF;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 0;
    phyRead(1, 1, v);
    check("R9 link wins bits 2 and 5", {16'h0, v}, 32'h00DB);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdData in reset", busRdData, 32'h0);
    rst_n = 1;
    testResetValues();
    testHostMap();
    testWriteRead();
    testForeign();
    testLinkAneg();
    testSoftReset();
    testCollision();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule